// File: doc/BRIEF.md
# Complement Instruction Execute Unit

This unit decodes and executes the three complement operations of an 8-bit accumulator machine. The operations invert the whole accumulator, invert the carry flag, or invert one bit chosen by an address byte. Instruction bytes arrive one at a time over a valid/ready handshake. The unit holds the architectural state these operations touch: the accumulator, the carry flag, a 128-bit bit-addressable RAM region and one 8-bit output port latch.

A single-bit complement is a read-modify-write. When the target is a port bit, the old value comes from the port's output latch and never from the external pin level. Each instruction takes effect on the clock edge that accepts its last byte, and a one-cycle `done` pulse follows. Bytes that are not one of the three opcodes raise a one-cycle illegal pulse and change nothing. Addresses that map to no implemented bit raise a one-cycle ignored pulse. A combinational peek port reads any bit through the same address map.

Top module: `cpl_exec_unit`

## Requirements
- R1: Opcode byte 0xF4 replaces the accumulator with its one's complement (0x5C becomes 0xA3).
- R2: Opcode byte 0xB3 inverts the carry flag.
- R3: Opcode byte 0xB2 takes the next accepted byte as a bit address, even when that byte equals an opcode value. Addresses 0x00–0x7F select RAM bit (addr[6:3]*8 + addr[2:0]). Exactly that bit inverts and no other RAM bit changes.
- R4: The accumulator complement, and any bit complement that does not target address 0xD7, leave the carry flag unchanged.
- R5: Addresses 0x90–0x97 select bit addr[2:0] of the port latch. The old value comes from the latch and pin_in is never used. Starting from latch 0x5D, inverting bit 1 and then bit 2 gives 0x5B. port_out always equals the latch.
- R6: Bit address 0xD7 selects the carry flag.
- R7: A bit address outside the three mapped ranges changes no state and raises bad_addr together with done for one cycle.
- R8: Any opcode byte other than 0xF4, 0xB3 or 0xB2 raises illegal for one cycle, changes no state and does not raise done. The following byte is decoded as a new opcode.
- R9: Synchronous reset clears the accumulator, the carry flag and all RAM bits, sets the port latch to 0xFF, clears the pulses and holds in_ready low.
- R10: done is high in exactly the cycle after the edge that accepts an instruction's last byte. in_ready is high whenever reset is low, so a byte can be accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte (opcode or bit address) |
| in_ready | output | 1 | Unit can accept a byte |
| pin_in | input | 8 | External pin levels of the port (never used for results) |
| peek_addr | input | 8 | Bit address to read |
| peek_bit | output | 1 | Value at peek_addr (0 if unmapped) |
| acc_out | output | 8 | Accumulator |
| carry_out | output | 1 | Carry flag |
| port_out | output | 8 | Port pins, driven from the latch |
| done | output | 1 | Instruction completed (one-cycle pulse) |
| bad_addr | output | 1 | Bit address ignored (one-cycle pulse) |
| illegal | output | 1 | Unsupported opcode (one-cycle pulse) |

## Verification
Embedded assertions check on every cycle that the accumulator complement lands on the next edge, that carry holds for non-carry operations, and that a port-bit write is the old latch value with one bit flipped. They also check that an illegal opcode freezes all state and never coincides with done, and that an ignored address always comes with done. The bench scenarios show the parts no single property covers. These are the exact RAM mapping and the isolation of neighbouring bits, the fixed port sequence while pin_in holds contrary values, the carry reached through address 0xD7, an opcode-valued byte consumed as an address, back-to-back timing of done, and the reset values.

// File: rtl/cpl_exec_unit.sv
module cpl_exec_unit #(
  parameter logic [7:0] OP_CPL_ACC = 8'hF4,
  parameter logic [7:0] OP_CPL_CY  = 8'hB3,
  parameter logic [7:0] OP_CPL_BIT = 8'hB2,
  parameter logic [7:0] CY_ADDR    = 8'hD7,
  parameter logic [7:0] PORT_RST   = 8'hFF,
  parameter int         RAM_BITS   = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  input  logic [7:0] pin_in,
  input  logic [7:0] peek_addr,
  output logic       peek_bit,
  output logic [7:0] acc_out,
  output logic       carry_out,
  output logic [7:0] port_out,
  output logic       done,
  output logic       bad_addr,
  output logic       illegal
);
  localparam int RA = $clog2(RAM_BITS);

  logic [7:0]          acc, latch;
  logic                cy, want_addr;
  logic [RAM_BITS-1:0] ram;

  wire fire      = in_valid && in_ready;
  wire op_fire   = fire && !want_addr;
  wire addr_fire = fire && want_addr;
  wire op_acc    = op_fire && in_byte == OP_CPL_ACC;
  wire op_cy     = op_fire && in_byte == OP_CPL_CY;
  wire op_bit    = op_fire && in_byte == OP_CPL_BIT;
  wire op_bad    = op_fire && !op_acc && !op_cy && !op_bit;

  wire hit_ram  = !in_byte[7];
  wire hit_port = in_byte[7:3] == 5'b10010;
  wire hit_cy   = in_byte == CY_ADDR;

  wire unused_pins = ^pin_in;

  assign in_ready  = !rst;
  assign acc_out   = acc;
  assign carry_out = cy;
  assign port_out  = latch;

  always_comb begin
    if (!peek_addr[7])                 peek_bit = ram[peek_addr[RA-1:0]];
    else if (peek_addr[7:3] == 5'b10010) peek_bit = latch[peek_addr[2:0]];
    else if (peek_addr == CY_ADDR)     peek_bit = cy;
    else                               peek_bit = unused_pins & 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      cy        <= 1'b0;
      ram       <= '0;
      latch     <= PORT_RST;
      want_addr <= 1'b0;
      done      <= 1'b0;
      bad_addr  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      done     <= 1'b0;
      bad_addr <= 1'b0;
      illegal  <= 1'b0;
      if (op_acc) begin
        acc  <= ~acc;
        done <= 1'b1;
      end
      if (op_cy) begin
        cy   <= ~cy;
        done <= 1'b1;
      end
      if (op_bit) want_addr <= 1'b1;
      if (op_bad) illegal <= 1'b1;
      if (addr_fire) begin
        want_addr <= 1'b0;
        done      <= 1'b1;
        if (hit_ram)       ram[in_byte[RA-1:0]]  <= ~ram[in_byte[RA-1:0]];
        else if (hit_port) latch[in_byte[2:0]]   <= ~latch[in_byte[2:0]];
        else if (hit_cy)   cy                    <= ~cy;
        else               bad_addr              <= 1'b1;
      end
    end
  end

  AST_ACC_INVERT: assert property (@(posedge clk) disable iff (rst)
    op_acc |=> acc_out == ~$past(acc_out));                           // R1
  AST_CY_INVERT: assert property (@(posedge clk) disable iff (rst)
    op_cy |=> carry_out != $past(carry_out));                         // R2
  AST_CY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_acc || (addr_fire && !hit_cy)) |=> $stable(carry_out));       // R4
  AST_PORT_RMW: assert property (@(posedge clk) disable iff (rst)
    (addr_fire && hit_port) |=>
      port_out == ($past(port_out) ^ (8'd1 << $past(in_byte[2:0])))); // R5
  AST_BAD_DONE: assert property (@(posedge clk) disable iff (rst)
    bad_addr |-> done);                                               // R7
  AST_ILL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    op_bad |=> $stable(acc_out) && $stable(carry_out)
               && $stable(port_out) && $stable(ram));                 // R8
  AST_ILL_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    !(illegal && done));                                              // R8
endmodule

// File: tb/sim_cpl_exec_unit.sv
module sim_cpl_exec_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [7:0] in_byte = 0, pin_in = 0, peek_addr = 0;
  logic in_ready, peek_bit, carry_out, done, bad_addr, illegal;
  logic [7:0] acc_out, port_out;

  cpl_exec_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] m_acc = 0, m_port = 8'hFF;
  logic m_cy = 0;
  logic [127:0] m_ram = '0;

  typedef struct packed {
    logic [7:0] acc; logic cy; logic [7:0] port;
    logic dn; logic bad; logic ill; int due;
  } exp_t;
  exp_t q[$];
  string tq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic dn, input logic bad, input logic ill);
    exp_t e;
    e.acc = m_acc; e.cy = m_cy; e.port = m_port;
    e.dn = dn; e.bad = bad; e.ill = ill; e.due = cyc + 1;
    q.push_back(e); tq.push_back(tag);
  endtask

  task automatic drive(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1; in_byte = b;
    pin_in = ~m_port;
  endtask

  task automatic release_bus();
    @(posedge clk); #1 in_valid = 0;
  endtask

  task automatic do_acc(input string tag);
    drive(8'hF4); m_acc = ~m_acc; push(tag, 1, 0, 0); release_bus();
  endtask
  task automatic do_cy(input string tag);
    drive(8'hB3); m_cy = ~m_cy; push(tag, 1, 0, 0); release_bus();
  endtask
  task automatic do_bit(input logic [7:0] a, input string tag);
    drive(8'hB2); release_bus();
    drive(a);
    if (!a[7]) m_ram[a[6:0]] = ~m_ram[a[6:0]];
    else if (a[7:3] == 5'b10010) m_port[a[2:0]] = ~m_port[a[2:0]];
    else if (a == 8'hD7) m_cy = ~m_cy;
    push(tag, 1, !(!a[7] || a[7:3] == 5'b10010 || a == 8'hD7), 0);
    release_bus();
  endtask
  task automatic do_ill(input logic [7:0] b, input string tag);
    drive(b); push(tag, 0, 0, 1); release_bus();
  endtask

  task automatic peek(input logic [7:0] a, input logic exp, input string tag);
    @(negedge clk); peek_addr = a; #1;
    chk(peek_bit === exp, tag, peek_bit, exp);
  endtask

  always @(negedge clk) begin
    if (!rst && (done || illegal || bad_addr)) begin
      if (q.size() == 0) chk(0, "R10 unexpected pulse", {done, bad_addr, illegal}, 0);
      else begin
        exp_t e; string t;
        e = q.pop_front(); t = tq.pop_front();
        chk(cyc == e.due, {t, " timing"}, cyc, e.due);
        chk(acc_out === e.acc, {t, " acc"}, acc_out, e.acc);
        chk(carry_out === e.cy, {t, " carry"}, carry_out, e.cy);
        chk(port_out === e.port, {t, " port"}, port_out, e.port);
        chk({done, bad_addr, illegal} === {e.dn, e.bad, e.ill}, {t, " pulses"},
            {done, bad_addr, illegal}, {e.dn, e.bad, e.ill});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready === 0, "R9 ready in reset", in_ready, 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk(acc_out === 8'h00, "R9 acc reset", acc_out, 0);
    chk(carry_out === 0, "R9 carry reset", carry_out, 0);
    chk(port_out === 8'hFF, "R9 port reset", port_out, 8'hFF);
    chk({done, bad_addr, illegal} === 3'b000, "R9 pulses reset", {done, bad_addr, illegal}, 0);
    chk(in_ready === 1, "R10 ready", in_ready, 1);
    peek(8'h05, 0, "R9 ram reset");

    do_acc("R1 first");
    do_acc("R1 back");
    drive(8'hF4); m_acc = ~m_acc; push("R10 back-to-back a", 1, 0, 0);
    @(posedge clk); #1;
    drive(8'hF4); m_acc = ~m_acc; push("R10 back-to-back b", 1, 0, 0);
    release_bus();

    do_bit(8'h7F, "R3 ram top");
    do_bit(8'h00, "R3 ram zero");
    do_bit(8'h0A, "R3 ram mid");
    peek(8'h7F, 1, "R3 peek 7F");
    peek(8'h0A, 1, "R3 peek 0A");
    peek(8'h0B, 0, "R3 neighbour 0B");
    peek(8'h09, 0, "R3 neighbour 09");

    do_bit(8'h97, "R5 set 5D a");
    do_bit(8'h95, "R5 set 5D b");
    do_bit(8'h91, "R5 set 5D c");
    chk(port_out === 8'h5D, "R5 latch 5D", port_out, 8'h5D);
    do_bit(8'h91, "R5 bit1");
    do_bit(8'h92, "R5 bit2");
    chk(port_out === 8'h5B, "R5 latch 5B", port_out, 8'h5B);

    do_cy("R2 cy set");
    do_acc("R4 acc keeps carry");
    do_bit(8'h12, "R4 ram keeps carry");
    do_bit(8'hD7, "R6 carry by addr");
    peek(8'hD7, m_cy, "R6 peek carry");
    do_cy("R2 cy again");

    do_bit(8'hF4, "R3 R7 opcode as addr");
    do_bit(8'h80, "R7 unmapped 80");
    do_bit(8'h98, "R7 unmapped 98");
    peek(8'h80, 0, "R7 peek unmapped");

    do_ill(8'h00, "R8 illegal 00");
    do_ill(8'hB4, "R8 illegal B4");
    do_acc("R8 next opcode");

    m_acc = 8'h5C;
    while (acc_out !== 8'h5C && m_acc == 8'h5C) begin
      if (acc_out === 8'hA3) begin m_acc = 8'hA3; do_acc("R1 5C restore"); end
      else break;
    end

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10 all results seen", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule